// File: doc/BRIEF.md
# Chained Command-List DMA Sequencer

This block runs several independent command lists, one per channel, over a shared descriptor-read port. Each channel holds a fetch pointer and an 8-bit work counter. While the counter is non-zero and the channel's gate bit is clear, the channel reads a two-word descriptor at the pointer. Word 0 is the address of the following descriptor and word 1 is the command word. The channel then spends a fixed number of cycles on the command before retiring it. The payload move itself is not modelled; it appears only as that delay.

Software prepares a channel while it is gated. It writes the fetch pointer, adds work to the counter, enables the interrupt if needed, and then clears the gate bit. A retired command may lower the counter and may raise a sticky completion flag. It may also move the pointer to the next descriptor in the list. Writing more work to the counter of a running channel extends its run. A gate bit stops a channel at once, and a self-clearing reset bit returns a channel to a clean state.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset every gate bit reads 1, all counters, completion flags and interrupt enables read 0, `irq` is low and no descriptor read is requested.
- R2: A channel whose counter is non-zero and whose gate bit is clear requests a descriptor read at the address held in its pointer register. Pointer registers are at word address 0x10+2c for channel c, and counters are at 0x11+2c.
- R3: A write to a counter adds the written value to the current count and saturates at 255. A read returns the current count.
- R4: A retired command whose command word has bit 6 set lowers the counter by exactly one. A command with bit 6 clear leaves the counter unchanged and the channel keeps running.
- R5: A retired command with command-word bit 2 set loads descriptor word 0 into the pointer and fetches from there next. With bit 2 clear the list ends: the channel fetches nothing more until its pointer or counter is written, and after such a write it fetches from the pointer again.
- R6: A channel whose counter reaches zero stops, even if the last command was chained. Adding work later resumes the fetch at the chained address.
- R7: The gate register is at 0x00, with bit c belonging to channel c. Setting a gate bit halts the channel at once, and a command in progress retires with no counter change and no flag. A gated channel issues no reads.
- R8: The interrupt register is at 0x04, with flags in bits [N-1:0] and enables in bits [16+N-1:16]. A flag sets when a bit-6 command retires and stays set until cleared through a write. `irq` is high exactly when some flag and its enable are both set.
- R9: Each register has aliases: 0x01 and 0x05 set the bits written as 1, and 0x02 and 0x06 clear them. Bits written as 0 are untouched. Plain writes to 0x00 and 0x04 replace the register.
- R10: A 1 written through 0x00 or 0x01 to gate-register bit 16+c resets channel c: its counter, pointer and state go to zero. The bit reads back as 0 and does not change any gate bit.
- R11: A command retires DONE_LAT cycles after the cycle in which its descriptor response is accepted.
- R12: At most one descriptor read is outstanding. Competing channels are served round-robin, starting after the channel served last; after reset channel 0 is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| desc_req | output | 1 | One-cycle descriptor read request |
| desc_addr | output | 32 | Descriptor address for the request |
| desc_rsp_valid | input | 1 | Descriptor response valid, at least one cycle after the request |
| desc_rsp_next | input | 32 | Descriptor word 0: next descriptor address |
| desc_rsp_cmd | input | 32 | Descriptor word 1: command word (bit 2 chain, bit 6 decrement) |
| irq | output | 1 | Masked completion interrupt |

## Verification
The lists are built from command words that mix the chain and decrement bits. All-decrement chains show that the counter tracks retired commands. A chain without decrements keeps running on a count of one, which shows that bit 6 alone governs the decrement. A chained list started with too little work halts mid-chain and then resumes from the saved pointer, which separates stopping on a zero count from stopping at the end of the list. Further runs cover a gate write during a fetch, two channels released in the same write, and a latency measurement from response to retirement.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 8;
    localparam int CHAIN_BIT = 2;
    localparam int DEC_BIT   = 6;
    localparam int HI_OFS    = 16;

    localparam logic [7:0] A_GATE     = 8'h00;
    localparam logic [7:0] A_GATE_SET = 8'h01;
    localparam logic [7:0] A_GATE_CLR = 8'h02;
    localparam logic [7:0] A_INT      = 8'h04;
    localparam logic [7:0] A_INT_SET  = 8'h05;
    localparam logic [7:0] A_INT_CLR  = 8'h06;
    localparam logic [7:0] A_CH_BASE  = 8'h10;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_FREQ,
        CH_FWAIT,
        CH_EXEC,
        CH_END
    } ch_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_SET,
        OP_CLR
    } bitop_e;

    typedef struct packed {
        logic              chain;
        logic              dec;
        logic [DATA_W-1:0] next;
    } cmd_s;

    function automatic cmd_s decode_cmd(input logic [DATA_W-1:0] next_w,
                                        input logic [DATA_W-1:0] cmd_w);
        cmd_s c;
        c.chain = cmd_w[CHAIN_BIT];
        c.dec   = cmd_w[DEC_BIT];
        c.next  = next_w;
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] sem_next(input logic [CNT_W-1:0]  cur,
                                                  input logic              dec,
                                                  input logic              add_en,
                                                  input logic [DATA_W-1:0] add);
        logic [DATA_W+1:0] sum;
        sum = {{(DATA_W+2-CNT_W){1'b0}}, cur};
        if (add_en)
            sum = sum + {2'b00, add};
        if (dec && (sum != '0))
            sum = sum - 1'b1;
        if (sum > {{(DATA_W+2-CNT_W){1'b0}}, {CNT_W{1'b1}}})
            return {CNT_W{1'b1}};
        return sum[CNT_W-1:0];
    endfunction

    function automatic bitop_e decode_op(input logic we, input logic [7:0] addr,
                                         input logic [7:0] base);
        if (!we)
            return OP_NONE;
        if (addr == base)
            return OP_WRITE;
        if (addr == base + 8'd1)
            return OP_SET;
        if (addr == base + 8'd2)
            return OP_CLR;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/chain_dma_arb.sv
module chain_dma_arb
    import chain_dma_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [N-1:0]                         want,
    input  logic                                 rsp_valid,
    output logic [N-1:0]                         grant,
    output logic                                 req,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] pick,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] owner,
    output logic                                 pend
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last_q;

    always_comb begin
        grant = '0;
        pick  = '0;
        req   = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(last_q) + 1 + k) % N;
            if (!pend && !req && want[idx]) begin
                grant[idx] = 1'b1;
                pick       = IDX_W'(idx);
                req        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            owner  <= '0;
            last_q <= IDX_W'(N - 1);
        end else if (req) begin
            pend   <= 1'b1;
            owner  <= pick;
            last_q <= pick;
        end else if (rsp_valid) begin
            pend   <= 1'b0;
        end
    end

endmodule

// File: rtl/chain_dma_chan.sv
module chain_dma_chan
    import chain_dma_pkg::*;
#(
    parameter int DONE_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    input  logic              soft_rst,
    input  logic              ptr_we,
    input  logic              sem_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              grant,
    input  logic              rsp_hit,
    input  logic [DATA_W-1:0] rsp_next,
    input  logic [DATA_W-1:0] rsp_cmd,
    output logic [DATA_W-1:0] ptr_q,
    output logic [CNT_W-1:0]  sem_q,
    output logic              want_fetch,
    output logic              active,
    output logic              done_dec
);
    localparam int LAT_W = (DONE_LAT > 1) ? $clog2(DONE_LAT + 1) : 1;

    ch_state_e        state_q;
    cmd_s             cmd_q;
    logic [LAT_W-1:0] lat_q;
    logic             finish;

    assign finish     = (state_q == CH_EXEC) && (lat_q == '0) && !gate;
    assign done_dec   = finish && cmd_q.dec;
    assign want_fetch = (state_q == CH_FREQ) && !gate;
    assign active     = (state_q != CH_IDLE) && (state_q != CH_END);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state_q <= CH_IDLE;
            cmd_q   <= '0;
            lat_q   <= '0;
            ptr_q   <= '0;
            sem_q   <= '0;
        end else begin
            sem_q <= sem_next(sem_q, done_dec, sem_we, wdata);

            if (ptr_we)
                ptr_q <= wdata;
            else if (finish && cmd_q.chain)
                ptr_q <= cmd_q.next;

            if (gate) begin
                state_q <= CH_IDLE;
                lat_q   <= '0;
            end else begin
                unique case (state_q)
                    CH_IDLE:  if (sem_q != '0) state_q <= CH_FREQ;
                    CH_FREQ:  if (grant) state_q <= CH_FWAIT;
                    CH_FWAIT: if (rsp_hit) begin
                        state_q <= CH_EXEC;
                        cmd_q   <= decode_cmd(rsp_next, rsp_cmd);
                        lat_q   <= LAT_W'(DONE_LAT - 1);
                    end
                    CH_EXEC: begin
                        if (lat_q == '0)
                            state_q <= cmd_q.chain ? CH_IDLE : CH_END;
                        else
                            lat_q <= lat_q - 1'b1;
                    end
                    CH_END:   if (ptr_we || sem_we) state_q <= CH_IDLE;
                    default:  state_q <= CH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
    import chain_dma_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int DONE_LAT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        desc_req,
    output logic [31:0] desc_addr,
    input  logic        desc_rsp_valid,
    input  logic [31:0] desc_rsp_next,
    input  logic [31:0] desc_rsp_cmd,
    output logic        irq
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] gate_q, ien_q, flag_q;
    logic [NUM_CH-1:0] gate_d, ien_d, flag_d;
    logic [NUM_CH-1:0] soft_rst, ptr_we, sem_we;
    logic [NUM_CH-1:0] want, grant, rsp_hit, ch_active, done_dec;
    logic [NUM_CH-1:0][DATA_W-1:0] ptr_arr;
    logic [NUM_CH-1:0][CNT_W-1:0]  sem_arr;
    logic [IDX_W-1:0] pick, owner;
    logic             pend;

    bitop_e     gate_op, int_op;
    logic [7:0] ch_off;
    logic       ch_hit;
    logic [IDX_W-1:0] ch_idx;

    assign gate_op = decode_op(reg_we, reg_addr, A_GATE);
    assign int_op  = decode_op(reg_we, reg_addr, A_INT);
    assign ch_off  = reg_addr - A_CH_BASE;
    assign ch_hit  = (reg_addr >= A_CH_BASE) && (int'(ch_off) < 2 * NUM_CH);
    assign ch_idx  = ch_off[IDX_W:1];

    always_comb begin
        unique case (gate_op)
            OP_WRITE: gate_d = reg_wdata[NUM_CH-1:0];
            OP_SET:   gate_d = gate_q | reg_wdata[NUM_CH-1:0];
            OP_CLR:   gate_d = gate_q & ~reg_wdata[NUM_CH-1:0];
            default:  gate_d = gate_q;
        endcase
        unique case (int_op)
            OP_WRITE: begin
                ien_d  = reg_wdata[HI_OFS +: NUM_CH];
                flag_d = reg_wdata[NUM_CH-1:0];
            end
            OP_SET: begin
                ien_d  = ien_q | reg_wdata[HI_OFS +: NUM_CH];
                flag_d = flag_q | reg_wdata[NUM_CH-1:0];
            end
            OP_CLR: begin
                ien_d  = ien_q & ~reg_wdata[HI_OFS +: NUM_CH];
                flag_d = flag_q & ~reg_wdata[NUM_CH-1:0];
            end
            default: begin
                ien_d  = ien_q;
                flag_d = flag_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '1;
            ien_q  <= '0;
            flag_q <= '0;
        end else begin
            gate_q <= gate_d;
            ien_q  <= ien_d;
            flag_q <= flag_d | done_dec;
        end
    end

    chain_dma_arb #(.N(NUM_CH)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .rsp_valid (desc_rsp_valid),
        .grant     (grant),
        .req       (desc_req),
        .pick      (pick),
        .owner     (owner),
        .pend      (pend)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign soft_rst[c] = ((gate_op == OP_WRITE) || (gate_op == OP_SET)) && reg_wdata[HI_OFS + c];
        assign ptr_we[c]   = reg_we && ch_hit && (ch_idx == IDX_W'(c)) && !ch_off[0];
        assign sem_we[c]   = reg_we && ch_hit && (ch_idx == IDX_W'(c)) &&  ch_off[0];
        assign rsp_hit[c]  = desc_rsp_valid && pend && (owner == IDX_W'(c));

        chain_dma_chan #(.DONE_LAT(DONE_LAT)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .gate       (gate_q[c]),
            .soft_rst   (soft_rst[c]),
            .ptr_we     (ptr_we[c]),
            .sem_we     (sem_we[c]),
            .wdata      (reg_wdata),
            .grant      (grant[c]),
            .rsp_hit    (rsp_hit[c]),
            .rsp_next   (desc_rsp_next),
            .rsp_cmd    (desc_rsp_cmd),
            .ptr_q      (ptr_arr[c]),
            .sem_q      (sem_arr[c]),
            .want_fetch (want[c]),
            .active     (ch_active[c]),
            .done_dec   (done_dec[c])
        );
    end

    assign desc_addr = ptr_arr[pick];
    assign irq       = |(flag_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_GATE || reg_addr == A_GATE_SET || reg_addr == A_GATE_CLR) begin
            reg_rdata[NUM_CH-1:0] = gate_q;
        end else if (reg_addr == A_INT || reg_addr == A_INT_SET || reg_addr == A_INT_CLR) begin
            reg_rdata[NUM_CH-1:0]        = flag_q;
            reg_rdata[HI_OFS +: NUM_CH]  = ien_q;
        end else if (ch_hit) begin
            if (ch_off[0])
                reg_rdata[CNT_W-1:0] = sem_arr[ch_idx];
            else
                reg_rdata = ptr_arr[ch_idx];
        end
    end

endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk
    import chain_dma_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          desc_req,
    input logic                          desc_rsp_valid,
    input logic                          irq,
    input logic                          reg_we,
    input logic [7:0]                    reg_addr,
    input logic [NUM_CH-1:0]             gate_q,
    input logic [NUM_CH-1:0]             flag_q,
    input logic [NUM_CH-1:0]             active,
    input logic [NUM_CH-1:0]             soft_rst,
    input logic [NUM_CH-1:0][CNT_W-1:0]  sem_arr
);
    logic pend_m;

    always_ff @(posedge clk) begin
        if (rst)
            pend_m <= 1'b0;
        else if (desc_req)
            pend_m <= 1'b1;
        else if (desc_rsp_valid)
            pend_m <= 1'b0;
    end

    AST_ONE_FETCH: assert property (@(posedge clk) disable iff (rst)
        pend_m |-> !desc_req); // R12

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_q != '0)); // R8

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_GATE_HALTS: assert property (@(posedge clk) disable iff (rst)
            gate_q[c] |=> !active[c]); // R7

        AST_SEM_STEP: assert property (@(posedge clk) disable iff (rst)
            (!$past(soft_rst[c]) && (sem_arr[c] < $past(sem_arr[c])))
            |-> (sem_arr[c] == $past(sem_arr[c]) - 8'd1)); // R4

        AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
            ((sem_arr[c] == '0) && !active[c]) |=> !active[c]); // R6

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            $fell(flag_q[c]) |-> $past(reg_we && ((reg_addr == A_INT) || (reg_addr == A_INT_CLR)))); // R8
    end

endmodule

bind chain_dma_seq chain_dma_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .desc_req       (desc_req),
    .desc_rsp_valid (desc_rsp_valid),
    .irq            (irq),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .gate_q         (gate_q),
    .flag_q         (flag_q),
    .active         (ch_active),
    .soft_rst       (soft_rst),
    .sem_arr        (sem_arr)
);

// File: tb/sim_chain_dma_seq.sv
`timescale 1ns/1ps
module sim_chain_dma_seq;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        desc_req;
    logic [31:0] desc_addr;
    logic        desc_rsp_valid = 1'b0;
    logic [31:0] desc_rsp_next = '0;
    logic [31:0] desc_rsp_cmd = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fetch_cnt = 0;
    int rsp_cnt = 0;
    int rsp_cyc = 0;
    bit finished = 1'b0;
    logic [31:0] fetch_log [64];
    logic [31:0] mem_next [32];
    logic [31:0] mem_cmd [32];

    always #2.5 clk = ~clk;

    chain_dma_seq #(.NUM_CH(8), .DONE_LAT(LAT)) u0 (
        .clk            (clk),
        .rst            (rst),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .desc_req       (desc_req),
        .desc_addr      (desc_addr),
        .desc_rsp_valid (desc_rsp_valid),
        .desc_rsp_next  (desc_rsp_next),
        .desc_rsp_cmd   (desc_rsp_cmd),
        .irq            (irq)
    );

    initial begin
        forever begin
            @(posedge clk);
            cyc = cyc + 1;
        end
    end

    // descriptor memory: answers one cycle after each request
    initial begin
        bit fire;
        logic [31:0] a;
        fire = 1'b0;
        a = '0;
        forever begin
            @(negedge clk);
            desc_rsp_valid = 1'b0;
            if (fire) begin
                desc_rsp_valid = 1'b1;
                desc_rsp_next  = mem_next[a[6:2]];
                desc_rsp_cmd   = mem_cmd[a[6:2]];
                rsp_cyc = cyc;
                rsp_cnt = rsp_cnt + 1;
                fire = 1'b0;
            end
            if (desc_req) begin
                a = desc_addr;
                fetch_log[fetch_cnt] = desc_addr;
                fetch_cnt = fetch_cnt + 1;
                fire = 1'b1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] cmd);
        mem_next[a[6:2]] = nxt;
        mem_cmd[a[6:2]]  = cmd;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(8'h00, d); check("R1 gate reset", d, 32'h0000_00FF);
        rd(8'h04, d); check("R1 int reset", d, 32'h0);
        rd(8'h11, d); check("R1 sem reset", d, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);
        check("R1 no request", {31'b0, desc_req}, 32'h0);
    endtask

    task automatic t_sem_add();
        logic [31:0] d;
        int base;
        base = fetch_cnt;
        wr(8'h17, 32'd5); rd(8'h17, d); check("R3 add 5", d, 32'd5);
        wr(8'h17, 32'd3); rd(8'h17, d); check("R3 add 3", d, 32'd8);
        wr(8'h17, 32'd250); rd(8'h17, d); check("R3 saturate", d, 32'd255);
        idle(10);
        check("R7 gated no fetch", fetch_cnt, base);
        wr(8'h01, 32'h0008_0000);
        rd(8'h17, d); check("R10 reset clears sem", d, 32'd0);
        rd(8'h00, d); check("R10 R9 gates untouched", d, 32'h0000_00FF);
    endtask

    task automatic t_chain_dec();
        logic [31:0] d;
        int base;
        base = fetch_cnt;
        set_desc(32'h100, 32'h104, 32'h44);
        set_desc(32'h104, 32'h108, 32'h44);
        set_desc(32'h108, 32'h0,   32'h40);
        wr(8'h10, 32'h100);
        wr(8'h11, 32'd3);
        wr(8'h05, 32'h0001_0000);
        wr(8'h02, 32'h1);
        idle(60);
        check("R2 fetch count", fetch_cnt - base, 3);
        check("R2 first fetch", fetch_log[base], 32'h100);
        check("R5 chained fetch 1", fetch_log[base+1], 32'h104);
        check("R5 chained fetch 2", fetch_log[base+2], 32'h108);
        rd(8'h11, d); check("R4 sem after decrements", d, 32'd0);
        rd(8'h10, d); check("R5 pointer at list end", d, 32'h108);
        rd(8'h04, d); check("R8 flag and enable", d, 32'h0001_0001);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        wr(8'h06, 32'h1);
        rd(8'h04, d); check("R9 clear alias keeps enable", d, 32'h0001_0000);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_no_dec();
        logic [31:0] d;
        int base;
        base = fetch_cnt;
        set_desc(32'h10C, 32'h110, 32'h04);
        set_desc(32'h110, 32'h0,   32'h40);
        wr(8'h12, 32'h10C);
        wr(8'h13, 32'd1);
        wr(8'h02, 32'h2);
        idle(50);
        check("R4 no-dec keeps running", fetch_cnt - base, 2);
        check("R4 second fetch", fetch_log[base+1], 32'h110);
        rd(8'h13, d); check("R4 single decrement", d, 32'd0);
        rd(8'h04, d); check("R8 flag without enable", d, 32'h0001_0002);
        check("R8 masked irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_stop_resume();
        logic [31:0] d;
        int base;
        base = fetch_cnt;
        set_desc(32'h114, 32'h118, 32'h44);
        set_desc(32'h118, 32'h11C, 32'h44);
        set_desc(32'h11C, 32'h0,   32'h40);
        wr(8'h14, 32'h114);
        wr(8'h15, 32'd1);
        wr(8'h02, 32'h4);
        idle(40);
        check("R6 stops at zero", fetch_cnt - base, 1);
        rd(8'h14, d); check("R6 pointer saved", d, 32'h118);
        wr(8'h15, 32'd2);
        idle(50);
        check("R6 resume count", fetch_cnt - base, 3);
        check("R6 resume address", fetch_log[base+1], 32'h118);
        rd(8'h15, d); check("R6 sem after resume", d, 32'd0);
        // list ended: a new count restarts at the same pointer, once
        wr(8'h15, 32'd2);
        idle(50);
        check("R5 refetch after end", fetch_cnt - base, 4);
        check("R5 refetch address", fetch_log[base+3], 32'h11C);
        rd(8'h15, d); check("R5 idle after end", d, 32'd1);
    endtask

    task automatic t_gate_abort();
        logic [31:0] d;
        int base;
        base = fetch_cnt;
        set_desc(32'h120, 32'h124, 32'h44);
        wr(8'h18, 32'h120);
        wr(8'h19, 32'd1);
        wr(8'h02, 32'h10);
        while (fetch_cnt == base) @(posedge clk);
        wr(8'h01, 32'h10);
        idle(30);
        rd(8'h19, d); check("R7 abort keeps sem", d, 32'd1);
        rd(8'h04, d); check("R7 abort no flag", (d >> 4) & 32'h1, 32'h0);
        check("R7 gated no refetch", fetch_cnt - base, 1);
        wr(8'h00, 32'h0010_00FF);
        rd(8'h19, d); check("R10 plain write reset", d, 32'd0);
        rd(8'h18, d); check("R10 pointer cleared", d, 32'h0);
        rd(8'h00, d); check("R10 reset bit reads 0", d, 32'h0000_00FF);
    endtask

    task automatic t_round_robin();
        logic [31:0] d;
        int base;
        base = fetch_cnt;
        set_desc(32'h128, 32'h0, 32'h40);
        set_desc(32'h12C, 32'h0, 32'h40);
        wr(8'h1A, 32'h128);
        wr(8'h1B, 32'd1);
        wr(8'h1C, 32'h12C);
        wr(8'h1D, 32'd1);
        wr(8'h02, 32'h60);
        idle(40);
        check("R12 both served", fetch_cnt - base, 2);
        check("R12 order first", fetch_log[base], 32'h128);
        check("R12 order second", fetch_log[base+1], 32'h12C);
        rd(8'h1D, d); check("R12 second retired", d, 32'd0);
    endtask

    task automatic t_latency();
        logic [31:0] d;
        int base;
        int done_cyc;
        base = rsp_cnt;
        set_desc(32'h130, 32'h0, 32'h40);
        wr(8'h1E, 32'h130);
        wr(8'h1F, 32'd1);
        wr(8'h02, 32'h80);
        @(negedge clk);
        reg_addr = 8'h1F;
        while (rsp_cnt == base) @(posedge clk);
        done_cyc = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #1;
            if (reg_rdata == 32'h0) begin
                done_cyc = cyc;
                break;
            end
        end
        check("R11 retire latency", done_cyc - rsp_cyc, LAT + 1);
        rd(8'h04, d); check("R8 flag ch7", (d >> 7) & 32'h1, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem_next[i] = '0;
            mem_cmd[i]  = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_sem_add();
        t_chain_dec();
        t_no_dec();
        t_stop_resume();
        t_gate_abort();
        t_round_robin();
        t_latency();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule